// File: doc/BRIEF.md
# Interrupt Flag and Request Aggregator

This block gathers six interrupt event sources into two banks of status flags and drives a single active-low interrupt request. Three sources land in a read-to-clear bank. Reading that bank returns a frozen view of its flags and clears them once the read ends. Events that arrive while the read is in progress are parked in a second latch and merged in afterwards, so none of them is lost. The other three sources land in a write-zero-to-clear bank, which software clears bit by bit.

Each source has its own enable bit. A flag records its event whether or not it is enabled, so software can poll without taking interrupts. The request goes low while any source has both its flag and its enable set. A summary bit in the read-to-clear status register mirrors the request.

Access goes through a simple synchronous port. `wr_stb` writes for one clock. `rd_stb` is held high for one or more clocks to mark a read cycle, and `addr` must stay constant while it is high. The address map is fixed: 0 is the read-to-clear status, 1 is the write-zero status, 2 is the read-to-clear enables and 3 is the write-zero enables. Flag i of a bank sits at data bit i, and the summary bit sits at bit 7.

Top module: `irq_flag_agg`

## Requirements
- R1: A one-clock pulse on any `ev_rc[i]` or `ev_wz[i]` sets flag i of its bank after that clock edge, whatever the matching enable bit holds.
- R2: While `rd_stb` is high with `addr`=0, `rdata[2:0]` holds the same value on every clock of the read, even if new events arrive.
- R3: On the first clock edge after `rd_stb` falls from a read of address 0, every read-to-clear flag that was returned is cleared to 0. A following read returns 0 for it, unless a new event has occurred since.
- R4: A read-to-clear event that arrives during the read, or on the clock edge where the read ends, shows up as a set flag once the read ends. It is reported exactly once.
- R5: Reading address 1 leaves its flags unchanged. Writing address 1 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R6: `irq_n` is 0 exactly when some source in either bank has both its flag and its enable set, and 1 otherwise, including after reset.
- R7: `irq_flag` and bit 7 of a read of address 0 equal the inverse of `irq_n`. They return to 0 once all enabled flags are cleared.
- R8: Writing an enable bit to 1 while its flag is already set drives `irq_n` low right after that write's clock edge.
- R9: If an event on a write-zero source coincides with a write that clears the same flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all flags and enables |
| ev_rc | input | 3 | Event pulses for the read-to-clear sources |
| ev_wz | input | 3 | Event pulses for the write-zero-to-clear sources |
| rd_stb | input | 1 | Read strobe, high for the whole read cycle |
| wr_stb | input | 1 | One-clock write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq_n | output | 1 | Active-low interrupt request |
| irq_flag | output | 1 | Summary flag, high while the request is asserted |

## Verification
A wrong flag or enable state shows up at `irq_n` and `irq_flag` on the very next clock after it forms, because both follow the stored bits through logic only. A lost or doubled deferred event shows up one read later: the read that follows a read cycle returns a flag that is missing or set twice. A clear that lands during the read, rather than after it, shows up as a change in `rdata` between two clocks of the same strobe.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   typedef enum logic [1:0] {
      REG_STAT_RC = 2'd0,
      REG_STAT_WZ = 2'd1,
      REG_EN_RC   = 2'd2,
      REG_EN_WZ   = 2'd3
   } irq_reg_e;

endpackage

// File: rtl/irq_rc_bank.sv
module irq_rc_bank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic         rd_sel,
   output logic [N-1:0] flags
);

   logic [N-1:0] flags_q;
   logic [N-1:0] pend_q;
   logic         rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         pend_q  <= '0;
         rd_q    <= 1'b0;
      end else begin
         rd_q <= rd_sel;
         if (rd_sel) begin
            pend_q <= pend_q | ev;
         end else if (rd_q) begin
            flags_q <= pend_q | ev;
            pend_q  <= '0;
         end else begin
            flags_q <= flags_q | ev;
         end
      end
   end

   assign flags = flags_q;

   a_r2_frozen_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sel |=> $stable(flags_q));

   a_r4_parked: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sel |=> ((pend_q & $past(ev)) == $past(ev)));

   a_r3_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_q && !rd_sel && pend_q == '0 && ev == '0) |=> (flags_q == '0));

   a_r1_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_sel && ev != '0) |=> ((flags_q & $past(ev)) == $past(ev)));

endmodule

// File: rtl/irq_wz_bank.sv
module irq_wz_bank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic         wr_sel,
   input  logic [N-1:0] keep,
   output logic [N-1:0] flags
);

   logic [N-1:0] flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else if (wr_sel) begin
         flags_q <= (flags_q & keep) | ev;
      end else begin
         flags_q <= flags_q | ev;
      end
   end

   assign flags = flags_q;

   a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (ev != '0) |=> ((flags_q & $past(ev)) == $past(ev)));

   a_r5_read_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_sel && ev == '0) |=> $stable(flags_q));

endmodule

// File: rtl/irq_req_merge.sv
module irq_req_merge #(
   parameter int N       = 6,
   parameter bit REG_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] flags,
   input  logic [N-1:0] en,
   output logic         irq_n
);

   logic any_hit;
   assign any_hit = |(flags & en);

   generate
      if (REG_OUT) begin : g_reg
         logic irq_n_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_n_q <= 1'b1;
            else        irq_n_q <= ~any_hit;
         end
         assign irq_n = irq_n_q;
      end else begin : g_comb
         assign irq_n = ~any_hit;
      end
   endgenerate

endmodule

// File: rtl/irq_flag_agg.sv
module irq_flag_agg
   import irq_agg_pkg::*;
#(
   parameter int N_RC    = 3,
   parameter int N_WZ    = 3,
   parameter int DATA_W  = 8,
   parameter bit REQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_RC-1:0]   ev_rc,
   input  logic [N_WZ-1:0]   ev_wz,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq_n,
   output logic              irq_flag
);

   localparam int N_ALL   = N_RC + N_WZ;
   localparam int SUM_BIT = DATA_W - 1;

   generate
      if (N_RC < 1 || N_RC + 1 > DATA_W) begin : g_bad_rc
         $error("irq_flag_agg: N_RC must be between 1 and DATA_W-1");
      end
      if (N_WZ < 1 || N_WZ > DATA_W) begin : g_bad_wz
         $error("irq_flag_agg: N_WZ must be between 1 and DATA_W");
      end
   endgenerate

   logic [N_RC-1:0] flags_rc, en_rc;
   logic [N_WZ-1:0] flags_wz, en_wz;
   logic            rd_rc_sel, wr_wz_sel;

   assign rd_rc_sel = rd_stb && (addr == REG_STAT_RC);
   assign wr_wz_sel = wr_stb && (addr == REG_STAT_WZ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_rc <= '0;
         en_wz <= '0;
      end else if (wr_stb) begin
         if (addr == REG_EN_RC) en_rc <= wdata[N_RC-1:0];
         if (addr == REG_EN_WZ) en_wz <= wdata[N_WZ-1:0];
      end
   end

   irq_rc_bank #(.N(N_RC)) i_rc (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (ev_rc),
      .rd_sel (rd_rc_sel),
      .flags  (flags_rc)
   );

   irq_wz_bank #(.N(N_WZ)) i_wz (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (ev_wz),
      .wr_sel (wr_wz_sel),
      .keep   (wdata[N_WZ-1:0]),
      .flags  (flags_wz)
   );

   irq_req_merge #(.N(N_ALL), .REG_OUT(REQ_REG)) i_req (
      .clk   (clk),
      .rst_n (rst_n),
      .flags ({flags_wz, flags_rc}),
      .en    ({en_wz, en_rc}),
      .irq_n (irq_n)
   );

   assign irq_flag = ~irq_n;

   always_comb begin
      rdata = '0;
      case (addr)
         REG_STAT_RC: begin
            rdata[N_RC-1:0] = flags_rc;
            rdata[SUM_BIT]  = irq_flag;
         end
         REG_STAT_WZ: rdata[N_WZ-1:0] = flags_wz;
         REG_EN_RC:   rdata[N_RC-1:0] = en_rc;
         default:     rdata[N_WZ-1:0] = en_wz;
      endcase
   end

   a_r7_summary_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == REG_STAT_RC) |-> (rdata[SUM_BIT] == !irq_n));

   a_r6_quiet_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (en_rc == '0 && en_wz == '0 && !REQ_REG) |-> irq_n);

endmodule

// File: tb/test_irq_flag_agg.sv
`timescale 1ns/1ps
module test_irq_flag_agg;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] ev_rc = '0, ev_wz = '0;
   logic       rd_stb = 1'b0, wr_stb = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq_n, irq_flag;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   irq_flag_agg i_irq_flag_agg (
      .clk(clk), .rst_n(rst_n), .ev_rc(ev_rc), .ev_wz(ev_wz),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq_n(irq_n), .irq_flag(irq_flag)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse(input logic [2:0] rc, input logic [2:0] wz);
      @(negedge clk); ev_rc = rc; ev_wz = wz;
      @(negedge clk); ev_rc = '0; ev_wz = '0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); wr_stb = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_stb = 1'b0;
   endtask

   // read held for n clocks; event mask evm driven at cycle ev_at (n = clear edge)
   task automatic rd(input string req, input logic [1:0] a, input int n,
                     input int ev_at, input logic [2:0] evm, input logic [7:0] exp);
      logic [7:0] first;
      @(negedge clk); rd_stb = 1'b1; addr = a;
      #1 first = rdata;
      check(req, first, exp);
      for (int k = 1; k < n; k++) begin
         @(negedge clk); ev_rc = (ev_at == k) ? evm : 3'b000;
         #1 check({req, " stable"}, rdata, first);
      end
      @(negedge clk); rd_stb = 1'b0; ev_rc = (ev_at == n) ? evm : 3'b000;
      @(negedge clk); ev_rc = '0;
   endtask

   task automatic t_reset;
      check("R6 reset irq_n", {7'd0, irq_n}, 8'h01);
      check("R7 reset irq_flag", {7'd0, irq_flag}, 8'h00);
      rd("R3 reset status", 2'd0, 1, -1, 3'b0, 8'h00);
      rd("R5 reset status", 2'd1, 1, -1, 3'b0, 8'h00);
   endtask

   task automatic t_poll;
      pulse(3'b001, 3'b100);
      check("R1 no irq when disabled", {7'd0, irq_n}, 8'h01);
      rd("R1 rc flag latched", 2'd0, 1, -1, 3'b0, 8'h01);
      rd("R1 wz flag latched", 2'd1, 1, -1, 3'b0, 8'h04);
      rd("R3 cleared after read", 2'd0, 1, -1, 3'b0, 8'h00);
      rd("R5 read leaves wz", 2'd1, 1, -1, 3'b0, 8'h04);
   endtask

   task automatic t_mid_read;
      pulse(3'b010, 3'b000);
      rd("R2 snapshot", 2'd0, 4, 1, 3'b100, 8'h02);
      rd("R4 deferred event", 2'd0, 1, -1, 3'b0, 8'h04);
      rd("R4 reported once", 2'd0, 1, -1, 3'b0, 8'h00);
      rd("R3 empty read", 2'd0, 1, 1, 3'b001, 8'h00);
      rd("R4 event at clear edge", 2'd0, 1, -1, 3'b0, 8'h01);
      rd("R4 edge event once", 2'd0, 1, -1, 3'b0, 8'h00);
   endtask

   task automatic t_wz;
      wr(2'd1, 8'hFF);
      rd("R5 write ones keeps", 2'd1, 1, -1, 3'b0, 8'h04);
      pulse(3'b000, 3'b011);
      wr(2'd1, 8'hFD);
      rd("R5 write zero clears bit", 2'd1, 1, -1, 3'b0, 8'h05);
      wr(2'd1, 8'h00);
      rd("R5 all cleared", 2'd1, 1, -1, 3'b0, 8'h00);
   endtask

   task automatic t_enable;
      pulse(3'b001, 3'b000);
      check("R6 flag without enable", {7'd0, irq_n}, 8'h01);
      wr(2'd2, 8'h01);
      check("R8 late enable asserts", {7'd0, irq_n}, 8'h00);
      check("R7 irq_flag high", {7'd0, irq_flag}, 8'h01);
      rd("R7 summary bit", 2'd0, 1, -1, 3'b0, 8'h81);
      check("R6 released after clear", {7'd0, irq_n}, 8'h01);
      check("R7 irq_flag low", {7'd0, irq_flag}, 8'h00);
      pulse(3'b010, 3'b000);
      check("R1 other source disabled", {7'd0, irq_n}, 8'h01);
      rd("R1 disabled flag polled", 2'd0, 1, -1, 3'b0, 8'h02);
      wr(2'd3, 8'h04);
      pulse(3'b000, 3'b100);
      check("R6 wz source asserts", {7'd0, irq_n}, 8'h00);
      rd("R7 summary from wz", 2'd0, 1, -1, 3'b0, 8'h80);
      wr(2'd1, 8'h00);
      check("R7 summary clears", {7'd0, irq_flag}, 8'h00);
   endtask

   task automatic t_collide;
      @(negedge clk); wr_stb = 1'b1; addr = 2'd1; wdata = 8'h00; ev_wz = 3'b010;
      @(negedge clk); wr_stb = 1'b0; ev_wz = '0;
      rd("R9 event beats clear", 2'd1, 1, -1, 3'b0, 8'h02);
      wr(2'd1, 8'h00);
      rd("R9 later clear works", 2'd1, 1, -1, 3'b0, 8'h00);
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_poll();
      t_mid_read();
      t_wz();
      t_enable();
      t_collide();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule